// File: doc/BRIEF.md
# Configuration Port Controller for an I/O Companion Device

This block is the configuration front end of a legacy I/O companion device on an 8-bit I/O bus. It answers on two consecutive byte addresses. The lower address is the index port and the upper one is the data port. The configuration registers are sealed after reset. A write of the unlock key to the index port opens them, and a write of the lock key to the same port seals them again.

While the registers are open, software writes a register number to the index port. It then reads or writes that register through the data port. One register picks a logical device number. The activate flag and the two base-address bytes are held separately for each logical device. A fixed, read-only identity byte lets probing software recognise the device. The address and activate flag held for one chosen logical device leave the block as registered outputs, so that the runtime register decoder can use them.

Top module: `sio_cfg_port`

## Requirements
- R1: After a synchronous reset the port is sealed, `rt_base` is 0x0000, `rt_active` is 0, `io_rdata` is 0xFF, the latched index and the device select are 0x00, and every banked register of every logical device is zero.
- R2: While sealed, a write of 0x55 to the index port (address `PORT_BASE`) opens the port and does not change the latched index. While sealed, other index-port values are ignored. While open, a write of 0x55 is latched as an ordinary index.
- R3: While open, a write of 0xAA to the index port seals the port. While sealed, data-port writes have no effect, and a read of either port returns 0xFF on `io_rdata` in the cycle after the read strobe.
- R4: While open, an index-port write of any value other than 0xAA latches that value as the index. A data-port access (address `PORT_BASE`+1) reaches the indexed register. Read data appears on `io_rdata` one cycle after `io_rd`.
- R5: Index 0x20 reads back the parameter `DEV_ID` (0x7C, 0x7D or 0x7F). Writes to it have no effect.
- R6: Index 0x07 holds the 8-bit logical device select. It reads back as written and keeps its value while the port is sealed.
- R7: Index 0x30 holds the activate flag of the selected device in bit 0. Bits 7:1 are not stored and read as zero.
- R8: Index 0x60 holds the high byte and index 0x61 the low byte of the base address of the selected device. Each device below `NUM_LDN` has its own copy. For a device select of `NUM_LDN` or above, writes to the banked registers are ignored and reads return 0x00.
- R9: `rt_base` and `rt_active` show the registers of logical device `RT_LDN` (0x0A). They change in the cycle after a data-port write to those registers. Writes to other devices leave them unchanged. A value of zero on `rt_base` means the address is unset.
- R10: While open, indexes that are not implemented read 0x00. Accesses to addresses other than the two ports change no state, and reads of them return 0xFF.
- R11: While open, a read of the index port returns the latched index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after `io_rd` |
| rt_base | output | 16 | Runtime base address of logical device `RT_LDN` |
| rt_active | output | 1 | Activate flag of logical device `RT_LDN` |

## Verification
A wrong lock state shows up at the first data-port read after a key write. Read data that should be 0xFF turns into register contents, or the reverse, within one cycle. A corrupted device select or broken banking moves `rt_base` or `rt_active` in the cycle after a write to a foreign device. It also makes a read of a device that was never written return a non-zero byte, one cycle after the read. A stale index shows at the next data-port read as the identity byte or the select value in the wrong place.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_SEAL  = 8'hAA;
  localparam logic [7:0] IX_LDSEL  = 8'h07;
  localparam logic [7:0] IX_IDENT  = 8'h20;
  localparam logic [7:0] IX_ACT    = 8'h30;
  localparam logic [7:0] IX_BASEHI = 8'h60;
  localparam logic [7:0] IX_BASELO = 8'h61;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic { LK_SEALED = 1'b0, LK_OPEN = 1'b1 } lock_e;
  typedef enum logic [1:0] { BF_NONE, BF_ACT, BF_HI, BF_LO } bank_fld_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  lock_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LK_SEALED;
    end else if (idx_wr) begin
      unique case (st_q)
        LK_SEALED: if (wdata == KEY_OPEN) st_q <= LK_OPEN;
        LK_OPEN:   if (wdata == KEY_SEAL) st_q <= LK_SEALED;
        default:   st_q <= LK_SEALED;
      endcase
    end
  end

  assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/sio_ldn_bank.sv
module sio_ldn_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDN = 16,
  parameter int RT_LDN  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  bank_fld_e  wr_fld,
  input  logic [7:0] ldn,
  input  logic [7:0] wdata,
  output logic       rd_act,
  output logic [7:0] rd_hi,
  output logic [7:0] rd_lo,
  output logic [15:0] rt_base,
  output logic       rt_active
);
  localparam int SEL_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  logic       act_a [NUM_LDN];
  logic [7:0] hi_a  [NUM_LDN];
  logic [7:0] lo_a  [NUM_LDN];

  logic            in_range;
  logic [SEL_W-1:0] sel;

  assign in_range = (int'(ldn) < NUM_LDN);
  assign sel      = ldn[SEL_W-1:0];

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
    logic       act_q;
    logic [7:0] hi_q;
    logic [7:0] lo_q;
    logic       hit;

    assign hit = wr_en && in_range && (int'(sel) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q <= 1'b0;
        hi_q  <= 8'h00;
        lo_q  <= 8'h00;
      end else if (hit) begin
        case (wr_fld)
          BF_ACT:  act_q <= wdata[0];
          BF_HI:   hi_q  <= wdata;
          BF_LO:   lo_q  <= wdata;
          default: ;
        endcase
      end
    end

    assign act_a[g] = act_q;
    assign hi_a[g]  = hi_q;
    assign lo_a[g]  = lo_q;
  end

  always_comb begin
    rd_act = 1'b0;
    rd_hi  = 8'h00;
    rd_lo  = 8'h00;
    if (in_range) begin
      rd_act = act_a[sel];
      rd_hi  = hi_a[sel];
      rd_lo  = lo_a[sel];
    end
  end

  assign rt_base   = {hi_a[RT_LDN], lo_a[RT_LDN]};
  assign rt_active = act_a[RT_LDN];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] PORT_BASE = 16'h002E,
  parameter logic [7:0]  DEV_ID    = 8'h7C,
  parameter int          NUM_LDN   = 16,
  parameter int          RT_LDN    = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [15:0] rt_base,
  output logic        rt_active
);
  localparam logic [15:0] DATA_ADDR = PORT_BASE + 16'd1;

  logic       idx_hit, dat_hit;
  logic       unlocked;
  logic [7:0] cur_index;
  logic [7:0] ldn_q;
  logic       bank_we;
  bank_fld_e  bank_fld;
  logic       b_act;
  logic [7:0] b_hi, b_lo;
  logic [7:0] reg_rd;

  assign idx_hit = (io_addr == PORT_BASE);
  assign dat_hit = (io_addr == DATA_ADDR);

  sio_key_fsm u_key (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (io_wr && idx_hit),
    .wdata  (io_wdata),
    .open_o (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_index <= 8'h00;
    end else if (unlocked && io_wr && idx_hit && io_wdata != KEY_SEAL) begin
      cur_index <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q <= 8'h00;
    end else if (unlocked && io_wr && dat_hit && cur_index == IX_LDSEL) begin
      ldn_q <= io_wdata;
    end
  end

  always_comb begin
    case (cur_index)
      IX_ACT:    bank_fld = BF_ACT;
      IX_BASEHI: bank_fld = BF_HI;
      IX_BASELO: bank_fld = BF_LO;
      default:   bank_fld = BF_NONE;
    endcase
  end

  assign bank_we = unlocked && io_wr && dat_hit && (bank_fld != BF_NONE);

  sio_ldn_bank #(
    .NUM_LDN (NUM_LDN),
    .RT_LDN  (RT_LDN)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bank_we),
    .wr_fld    (bank_fld),
    .ldn       (ldn_q),
    .wdata     (io_wdata),
    .rd_act    (b_act),
    .rd_hi     (b_hi),
    .rd_lo     (b_lo),
    .rt_base   (rt_base),
    .rt_active (rt_active)
  );

  always_comb begin
    case (cur_index)
      IX_LDSEL:  reg_rd = ldn_q;
      IX_IDENT:  reg_rd = DEV_ID;
      IX_ACT:    reg_rd = {7'b0, b_act};
      IX_BASEHI: reg_rd = b_hi;
      IX_BASELO: reg_rd = b_lo;
      default:   reg_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= IDLE_BYTE;
    end else if (io_rd) begin
      if (unlocked && dat_hit)      io_rdata <= reg_rd;
      else if (unlocked && idx_hit) io_rdata <= cur_index;
      else                          io_rdata <= IDLE_BYTE;
    end
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [15:0] PORT_BASE = 16'h002E,
  parameter logic [7:0]  DEV_ID    = 8'h7C
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [15:0] rt_base,
  input logic        rt_active,
  input logic        unlocked,
  input logic [7:0]  cur_index
);
  logic idx_a, dat_a;
  assign idx_a = (io_addr == PORT_BASE);
  assign dat_a = (io_addr == PORT_BASE + 16'd1);

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rt_base == 16'h0000 && !rt_active && io_rdata == 8'hFF && !unlocked));

  p_key_open_r2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && io_wr && idx_a && io_wdata == 8'h55) |=> unlocked);

  p_sealed_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && io_wr && idx_a && io_wdata != 8'h55) |=> !unlocked);

  p_key_seal_r3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && io_wr && idx_a && io_wdata == 8'hAA) |=> !unlocked);

  p_sealed_read_r3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !unlocked) |=> io_rdata == 8'hFF);

  p_ident_read_r5: assert property (@(posedge clk) disable iff (rst)
    (io_rd && unlocked && dat_a && cur_index == 8'h20) |=> io_rdata == DEV_ID);

  p_rt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && unlocked && dat_a) |=> ($stable(rt_base) && $stable(rt_active)));

  p_index_read_r11: assert property (@(posedge clk) disable iff (rst)
    (io_rd && unlocked && idx_a && !io_wr) |=> io_rdata == $past(cur_index));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.PORT_BASE(PORT_BASE), .DEV_ID(DEV_ID)) u_chk (.*);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic [15:0] rt_base;
  logic        rt_active;

  int n_run  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sio_cfg_port #(.PORT_BASE(16'h002E), .DEV_ID(8'h7C), .NUM_LDN(16), .RT_LDN(10)) u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .rt_base(rt_base), .rt_active(rt_active)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RTB = 2'd2, OP_RTA = 2'd3;
  localparam logic [15:0] PX = 16'h002E, PD = 16'h002F, PO = 16'h004E;
  localparam int NV = 57;
  // {requirement number, op, address, data or expected}
  localparam logic [41:0] VEC [NV] = '{
    {8'd3,  OP_RD,  PD, 16'h00FF},   // R3 sealed read
    {8'd3,  OP_WR,  PD, 16'h0012},   // R3 ignored
    {8'd2,  OP_WR,  PX, 16'h0007},   // R2 ignored while sealed
    {8'd3,  OP_RD,  PX, 16'h00FF},   // R3
    {8'd2,  OP_WR,  PX, 16'h0055},   // R2 open
    {8'd11, OP_RD,  PX, 16'h0000},   // R11 index untouched by key
    {8'd4,  OP_WR,  PX, 16'h0020},
    {8'd5,  OP_RD,  PD, 16'h007C},   // R5
    {8'd5,  OP_WR,  PD, 16'h0099},
    {8'd5,  OP_RD,  PD, 16'h007C},   // R5 write ignored
    {8'd6,  OP_WR,  PX, 16'h0007},
    {8'd6,  OP_WR,  PD, 16'h000A},
    {8'd6,  OP_RD,  PD, 16'h000A},   // R6
    {8'd11, OP_RD,  PX, 16'h0007},   // R11
    {8'd8,  OP_WR,  PX, 16'h0060},
    {8'd8,  OP_WR,  PD, 16'h0012},
    {8'd8,  OP_WR,  PX, 16'h0061},
    {8'd8,  OP_WR,  PD, 16'h0034},
    {8'd9,  OP_RTB, PD, 16'h1234},   // R9
    {8'd7,  OP_WR,  PX, 16'h0030},
    {8'd7,  OP_WR,  PD, 16'h00FF},
    {8'd7,  OP_RD,  PD, 16'h0001},   // R7 only bit 0 kept
    {8'd9,  OP_RTA, PD, 16'h0001},   // R9
    {8'd6,  OP_WR,  PX, 16'h0007},
    {8'd6,  OP_WR,  PD, 16'h0003},
    {8'd8,  OP_WR,  PX, 16'h0060},
    {8'd8,  OP_RD,  PD, 16'h0000},   // R8 other device starts at zero
    {8'd8,  OP_WR,  PD, 16'h00AB},
    {8'd8,  OP_RD,  PD, 16'h00AB},   // R8
    {8'd9,  OP_RTB, PD, 16'h1234},   // R9 foreign write
    {8'd7,  OP_WR,  PX, 16'h0030},
    {8'd7,  OP_RD,  PD, 16'h0000},   // R7 banked flag
    {8'd6,  OP_WR,  PX, 16'h0007},
    {8'd6,  OP_WR,  PD, 16'h000A},
    {8'd8,  OP_WR,  PX, 16'h0060},
    {8'd8,  OP_RD,  PD, 16'h0012},   // R8 kept per device
    {8'd6,  OP_WR,  PX, 16'h0007},
    {8'd6,  OP_WR,  PD, 16'h0040},
    {8'd8,  OP_WR,  PX, 16'h0061},
    {8'd8,  OP_WR,  PD, 16'h0077},
    {8'd8,  OP_RD,  PD, 16'h0000},   // R8 out of range
    {8'd10, OP_WR,  PX, 16'h0045},
    {8'd10, OP_RD,  PD, 16'h0000},   // R10 unimplemented
    {8'd10, OP_WR,  PO, 16'h00AA},
    {8'd10, OP_RD,  PO, 16'h00FF},   // R10 foreign address
    {8'd10, OP_RD,  PX, 16'h0045},   // R10 still open, index kept
    {8'd2,  OP_WR,  PX, 16'h0055},
    {8'd2,  OP_RD,  PX, 16'h0055},   // R2 key latched while open
    {8'd3,  OP_WR,  PX, 16'h00AA},
    {8'd3,  OP_RD,  PD, 16'h00FF},   // R3 sealed again
    {8'd3,  OP_WR,  PD, 16'h0000},
    {8'd9,  OP_RTA, PD, 16'h0001},   // R9 sealed write ignored
    {8'd2,  OP_WR,  PX, 16'h0055},
    {8'd6,  OP_WR,  PX, 16'h0007},
    {8'd6,  OP_RD,  PD, 16'h0040},   // R6 select survives sealing
    {8'd4,  OP_RD,  PD, 16'h0040},   // R4 repeat read
    {8'd3,  OP_WR,  PX, 16'h00AA}
  };

  task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, rt_base, 16'h0000);
    check(1, {15'b0, rt_active}, 16'h0000);
    check(1, {8'h00, io_rdata}, 16'h00FF);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  rq;
      logic [1:0]  op;
      logic [15:0] ad, dv;
      {rq, op, ad, dv} = VEC[i];
      case (op)
        OP_WR:  bus_wr(ad, dv[7:0]);
        OP_RD:  begin bus_rd(ad, rd); check(int'(rq), {8'h00, rd}, dv); end
        OP_RTB: check(int'(rq), rt_base, dv);
        default: check(int'(rq), {15'b0, rt_active}, dv);
      endcase
    end

    // R1 reset in mid-run clears banks and seals the port
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1, rt_base, 16'h0000);
    check(1, {15'b0, rt_active}, 16'h0000);
    bus_rd(PD, rd);
    check(1, {8'h00, rd}, 16'h00FF);
    bus_wr(PX, 8'h55);
    bus_wr(PX, 8'h07);
    bus_rd(PD, rd);
    check(1, {8'h00, rd}, 16'h0000);
    bus_wr(PD, 8'h0A);
    bus_wr(PX, 8'h61);
    bus_rd(PD, rd);
    check(1, {8'h00, rd}, 16'h0000);
    // R4 write then read through the data port, R9 low byte only
    bus_wr(PD, 8'h5A);
    bus_rd(PD, rd);
    check(4, {8'h00, rd}, 16'h005A);
    check(9, rt_base, 16'h005A);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule